// File: doc/BRIEF.md
# Multiplexed Address / General-Purpose I/O Port Pair

This block holds the data registers of two 8-bit ports that together form the upper and lower bytes of a 16-bit external address bus. In single-chip operation every pin is general-purpose I/O. Each pin's output enable follows its direction bit, and its output value follows its register bit. In the expanded and emulation modes all sixteen pads drive outward. A phase input picks between the internal address and the internal visibility data. Bit 0 of the lower port can carry an upper-data-strobe level in place of address bit 0.

Software reaches the two registers through a single-cycle register bus. A read returns, per bit, the stored value for output bits and the pad level for input bits. In emulation mode a read returns the external bus data instead, and a write is also copied out as a one-cycle external write request. A write always updates the local register, whatever the pins are doing at the time.

A small access state machine registers each bus operation. Its states are `ACC_IDLE` (no access last cycle), `ACC_RD_LOCAL` (read data from the local sources is presented), `ACC_RD_EXT` (read data from the external bus is presented), `ACC_WR_LOCAL` (local write done) and `ACC_WR_EXT` (local write done and the external write request is driven). Every cycle the next state is chosen from that cycle's request alone:
- a write goes to `ACC_WR_EXT` in emulation mode and to `ACC_WR_LOCAL` otherwise;
- a read without a write goes to `ACC_RD_EXT` in emulation mode and to `ACC_RD_LOCAL` otherwise;
- no request returns the machine to `ACC_IDLE`.

Mode codes are 00 single-chip, 01 expanded, 10 emulation and 11 expanded (treated as 01). The port select is 0 for the upper port and 1 for the lower port.

Top module: `amux_port`

## Requirements
- R1: After reset both port registers hold 0x00, `reg_rvalid` and `ext_wr_req` are 0, and the state machine is in `ACC_IDLE`.
- R2: A cycle with `reg_wr`=1 loads `reg_wdata` into the register chosen by `reg_sel` (0 upper, 1 lower). The new value is visible from the next cycle, in every mode.
- R3: In mode 00, for each port, `pad_oe` equals the direction bits and `pad_out` equals the register.
- R4: Outside mode 10, a `reg_rd` cycle without `reg_wr` gives `reg_rvalid`=1 in the next cycle. `reg_rdata` then equals (register AND direction) OR (pad input AND NOT direction), using the values seen in the request cycle.
- R5: In modes 01, 10 and 11 all 16 output enables are 1. With `vis_phase`=0 the pads drive `int_addr` (upper port bits 15..8, lower port bits 7..0). With `vis_phase`=1 they drive `vis_data` in the same bit order.
- R6: In modes 01, 10 and 11 with `uds_en`=1, lower pad bit 0 drives `uds_val` in both phases, and the other bits are unchanged.
- R7: In mode 10 a read raises `ext_rd_req` during the request cycle. In the next cycle it returns, in `reg_rdata`, the `ext_rd_data` sampled in the request cycle.
- R8: In mode 10 a write produces, in the next cycle, a single-cycle `ext_wr_req` carrying the written select and data. In the other modes `ext_wr_req` stays 0.
- R9: A write made while the pins carry address or visibility data still updates the register. The value appears on the pads once the mode returns to 00.
- R10: When `reg_rd` and `reg_wr` are both 1 in one cycle, the write is performed and the read is dropped, so `reg_rvalid` stays 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Operating mode code |
| ddr_hi | input | 8 | Direction bits, upper port (1 = output) |
| ddr_lo | input | 8 | Direction bits, lower port |
| pad_in_hi | input | 8 | Buffered pad inputs, upper port |
| pad_in_lo | input | 8 | Buffered pad inputs, lower port |
| reg_sel | input | 1 | Register select: 0 upper, 1 lower |
| reg_rd | input | 1 | Register read request |
| reg_wr | input | 1 | Register write request |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after the request |
| ext_rd_data | input | 8 | Data returned by the external bus |
| ext_rd_req | output | 1 | External read request (mode 10) |
| ext_wr_req | output | 1 | External write request pulse (mode 10) |
| ext_wr_sel | output | 1 | Port select of the external write |
| ext_wr_data | output | 8 | Data of the external write |
| int_addr | input | 16 | Internal address for the address phase |
| vis_data | input | 16 | Internal visibility data |
| vis_phase | input | 1 | 0 address phase, 1 visibility phase |
| uds_en | input | 1 | Lower bit 0 carries the data strobe |
| uds_val | input | 1 | Data strobe level |
| pad_out_hi | output | 8 | Pad output values, upper port |
| pad_out_lo | output | 8 | Pad output values, lower port |
| pad_oe_hi | output | 8 | Pad output enables, upper port |
| pad_oe_lo | output | 8 | Pad output enables, lower port |

## Verification
A corrupted port register shows on the pads in the first cycle of single-chip operation with the direction bits set. It also shows in the `reg_rdata` of the next local read. Both expose it one cycle after the bad write. A wrong access state shows in the cycle after the request: as a read valid that was not asked for, as a dropped valid, as an external write request in a mode that forbids it, or as read data taken from the wrong source. A scoreboard that expects exactly one result per request catches each of these.

// File: rtl/amux_pkg.sv
package amux_pkg;

    typedef enum logic [1:0] {
        MODE_SINGLE       = 2'b00,
        MODE_EXPANDED     = 2'b01,
        MODE_EMULATION    = 2'b10,
        MODE_EXPANDED_ALT = 2'b11
    } mode_e;

    typedef enum logic [2:0] {
        ACC_IDLE     = 3'd0,
        ACC_RD_LOCAL = 3'd1,
        ACC_RD_EXT   = 3'd2,
        ACC_WR_LOCAL = 3'd3,
        ACC_WR_EXT   = 3'd4
    } acc_state_e;

    localparam int NUM_PORTS = 2;

    function automatic logic pins_on_bus(input logic [1:0] m);
        return m != MODE_SINGLE;
    endfunction

    function automatic logic is_emulation(input logic [1:0] m);
        return m == MODE_EMULATION;
    endfunction

endpackage

// File: rtl/amux_port_reg.sv
module amux_port_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_en) begin
            q <= wdata;
        end
    end

    // R2
    reg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (q == $past(wdata)));

endmodule

// File: rtl/amux_pin_mux.sv
module amux_pin_mux
    import amux_pkg::*;
#(
    parameter int W       = 8,
    parameter bit USE_UDS = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   mode,
    input  logic [W-1:0] ddr,
    input  logic [W-1:0] reg_q,
    input  logic [W-1:0] addr_byte,
    input  logic [W-1:0] vis_byte,
    input  logic         vis_phase,
    input  logic         uds_en,
    input  logic         uds_val,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe
);

    logic [W-1:0] bus_byte;
    logic [W-1:0] bus_drive;

    always_comb begin
        bus_byte = vis_phase ? vis_byte : addr_byte;
    end

    if (USE_UDS) begin : g_uds
        always_comb begin
            bus_drive    = bus_byte;
            bus_drive[0] = uds_en ? uds_val : bus_byte[0];
        end
    end else begin : g_plain
        logic unused_uds;
        always_comb begin
            bus_drive  = bus_byte;
            unused_uds = uds_en ^ uds_val;
        end
    end

    always_comb begin
        if (pins_on_bus(mode)) begin
            pad_out = bus_drive;
            pad_oe  = '1;
        end else begin
            pad_out = reg_q;
            pad_oe  = ddr;
        end
    end

    // R5
    bus_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_SINGLE) |-> (&pad_oe));

    // R3
    gpio_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SINGLE) |-> (pad_oe == ddr && pad_out == reg_q));

endmodule

// File: rtl/amux_access_fsm.sv
module amux_access_fsm
    import amux_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   mode,
    input  logic         reg_sel,
    input  logic         reg_rd,
    input  logic         reg_wr,
    input  logic [W-1:0] reg_wdata,
    input  logic [W-1:0] ddr_hi,
    input  logic [W-1:0] ddr_lo,
    input  logic [W-1:0] q_hi,
    input  logic [W-1:0] q_lo,
    input  logic [W-1:0] pad_in_hi,
    input  logic [W-1:0] pad_in_lo,
    input  logic [W-1:0] ext_rd_data,
    output logic [W-1:0] reg_rdata,
    output logic         reg_rvalid,
    output logic         ext_rd_req,
    output logic         ext_wr_req,
    output logic         ext_wr_sel,
    output logic [W-1:0] ext_wr_data
);

    acc_state_e   state_q, state_d;
    logic [W-1:0] sel_ddr, sel_q, sel_pad, local_val;
    logic [W-1:0] data_q;
    logic         sel_hold_q;

    always_comb begin
        sel_ddr   = reg_sel ? ddr_lo    : ddr_hi;
        sel_q     = reg_sel ? q_lo      : q_hi;
        sel_pad   = reg_sel ? pad_in_lo : pad_in_hi;
        local_val = (sel_q & sel_ddr) | (sel_pad & ~sel_ddr);
    end

    always_comb begin
        if (reg_wr) begin
            state_d = is_emulation(mode) ? ACC_WR_EXT : ACC_WR_LOCAL;
        end else if (reg_rd) begin
            state_d = is_emulation(mode) ? ACC_RD_EXT : ACC_RD_LOCAL;
        end else begin
            state_d = ACC_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ACC_IDLE;
            data_q     <= '0;
            sel_hold_q <= 1'b0;
        end else begin
            state_q <= state_d;
            unique case (state_d)
                ACC_RD_LOCAL: data_q <= local_val;
                ACC_RD_EXT:   data_q <= ext_rd_data;
                ACC_WR_EXT: begin
                    data_q     <= reg_wdata;
                    sel_hold_q <= reg_sel;
                end
                default:      data_q <= data_q;
            endcase
        end
    end

    always_comb begin
        reg_rvalid  = 1'b0;
        ext_wr_req  = 1'b0;
        reg_rdata   = '0;
        ext_wr_data = '0;
        ext_wr_sel  = 1'b0;
        unique case (state_q)
            ACC_IDLE:     ;
            ACC_RD_LOCAL,
            ACC_RD_EXT: begin
                reg_rvalid = 1'b1;
                reg_rdata  = data_q;
            end
            ACC_WR_LOCAL: ;
            ACC_WR_EXT: begin
                ext_wr_req  = 1'b1;
                ext_wr_data = data_q;
                ext_wr_sel  = sel_hold_q;
            end
            default:      ;
        endcase
        ext_rd_req = reg_rd & ~reg_wr & is_emulation(mode);
    end

    // R4
    rvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rvalid |-> $past(reg_rd && !reg_wr));

    // R10
    rd_wr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_wr) |=> !reg_rvalid);

    // R8
    ext_wr_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_wr_req |-> $past(reg_wr && mode == MODE_EMULATION));

    // R7
    ext_rd_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_wr && mode == MODE_EMULATION) |=>
            (reg_rvalid && reg_rdata == $past(ext_rd_data)));

endmodule

// File: rtl/amux_port.sv
module amux_port
    import amux_pkg::*;
#(
    parameter int PORT_W = 8,
    localparam int ADDR_W = 2 * PORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic [PORT_W-1:0] ddr_hi,
    input  logic [PORT_W-1:0] ddr_lo,
    input  logic [PORT_W-1:0] pad_in_hi,
    input  logic [PORT_W-1:0] pad_in_lo,
    input  logic              reg_sel,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [PORT_W-1:0] reg_wdata,
    output logic [PORT_W-1:0] reg_rdata,
    output logic              reg_rvalid,
    input  logic [PORT_W-1:0] ext_rd_data,
    output logic              ext_rd_req,
    output logic              ext_wr_req,
    output logic              ext_wr_sel,
    output logic [PORT_W-1:0] ext_wr_data,
    input  logic [ADDR_W-1:0] int_addr,
    input  logic [ADDR_W-1:0] vis_data,
    input  logic              vis_phase,
    input  logic              uds_en,
    input  logic              uds_val,
    output logic [PORT_W-1:0] pad_out_hi,
    output logic [PORT_W-1:0] pad_out_lo,
    output logic [PORT_W-1:0] pad_oe_hi,
    output logic [PORT_W-1:0] pad_oe_lo
);

    // index 0 = upper port, index 1 = lower port
    logic [NUM_PORTS-1:0][PORT_W-1:0] q_a, ddr_a, out_a, oe_a;

    always_comb begin
        ddr_a[0] = ddr_hi;
        ddr_a[1] = ddr_lo;
    end

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        amux_port_reg #(.W(PORT_W)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (reg_wr && (reg_sel == g[0])),
            .wdata (reg_wdata),
            .q     (q_a[g])
        );

        amux_pin_mux #(.W(PORT_W), .USE_UDS(g == 1)) u_mux (
            .clk       (clk),
            .rst_n     (rst_n),
            .mode      (mode),
            .ddr       (ddr_a[g]),
            .reg_q     (q_a[g]),
            .addr_byte (int_addr[(NUM_PORTS-1-g)*PORT_W +: PORT_W]),
            .vis_byte  (vis_data[(NUM_PORTS-1-g)*PORT_W +: PORT_W]),
            .vis_phase (vis_phase),
            .uds_en    (uds_en),
            .uds_val   (uds_val),
            .pad_out   (out_a[g]),
            .pad_oe    (oe_a[g])
        );
    end

    amux_access_fsm #(.W(PORT_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode),
        .reg_sel     (reg_sel),
        .reg_rd      (reg_rd),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .ddr_hi      (ddr_hi),
        .ddr_lo      (ddr_lo),
        .q_hi        (q_a[0]),
        .q_lo        (q_a[1]),
        .pad_in_hi   (pad_in_hi),
        .pad_in_lo   (pad_in_lo),
        .ext_rd_data (ext_rd_data),
        .reg_rdata   (reg_rdata),
        .reg_rvalid  (reg_rvalid),
        .ext_rd_req  (ext_rd_req),
        .ext_wr_req  (ext_wr_req),
        .ext_wr_sel  (ext_wr_sel),
        .ext_wr_data (ext_wr_data)
    );

    always_comb begin
        pad_out_hi = out_a[0];
        pad_out_lo = out_a[1];
        pad_oe_hi  = oe_a[0];
        pad_oe_lo  = oe_a[1];
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!reg_rvalid && !ext_wr_req));

endmodule

// File: tb/amux_port_tb_top.sv
module amux_port_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [7:0]  ddr_hi = '0, ddr_lo = '0, pad_in_hi = '0, pad_in_lo = '0;
    logic        reg_sel = 1'b0, reg_rd = 1'b0, reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0, ext_rd_data = '0;
    logic [15:0] int_addr = '0, vis_data = '0;
    logic        vis_phase = 1'b0, uds_en = 1'b0, uds_val = 1'b0;
    logic [7:0]  reg_rdata, ext_wr_data, pad_out_hi, pad_out_lo, pad_oe_hi, pad_oe_lo;
    logic        reg_rvalid, ext_rd_req, ext_wr_req, ext_wr_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // scoreboard item: {kind(1 = ext write), sel, data}
    logic [9:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    amux_port dut_i (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .ddr_hi(ddr_hi), .ddr_lo(ddr_lo), .pad_in_hi(pad_in_hi), .pad_in_lo(pad_in_lo),
        .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .ext_rd_data(ext_rd_data),
        .ext_rd_req(ext_rd_req), .ext_wr_req(ext_wr_req), .ext_wr_sel(ext_wr_sel),
        .ext_wr_data(ext_wr_data), .int_addr(int_addr), .vis_data(vis_data),
        .vis_phase(vis_phase), .uds_en(uds_en), .uds_val(uds_val),
        .pad_out_hi(pad_out_hi), .pad_out_lo(pad_out_lo),
        .pad_oe_hi(pad_oe_hi), .pad_oe_lo(pad_oe_lo)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_read(input logic sel, input logic [7:0] exp, input string tag);
        @(posedge clk); #1;
        reg_sel = sel; reg_rd = 1'b1;
        exp_q.push_back({1'b0, 1'b0, exp});
        tag_q.push_back(tag);
        #1 check({tag, " ext_rd_req"}, 16'(ext_rd_req), 16'(mode == 2'b10));
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic do_write(input logic sel, input logic [7:0] d, input logic also_rd,
                            input string tag);
        @(posedge clk); #1;
        reg_sel = sel; reg_wr = 1'b1; reg_wdata = d; reg_rd = also_rd;
        if (mode == 2'b10) begin
            exp_q.push_back({1'b1, sel, d});
            tag_q.push_back(tag);
        end
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_rd = 1'b0;
    endtask

    // monitor: every result must match the oldest pending expectation
    always @(negedge clk) begin
        if (rst_n && (reg_rvalid || ext_wr_req)) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R10/R8 unexpected result: actual rv=%b ew=%b data=%h expected none",
                         reg_rvalid, ext_wr_req, reg_rvalid ? reg_rdata : ext_wr_data);
            end else begin
                logic [9:0] e;
                logic [9:0] a;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = reg_rvalid ? {1'b0, 1'b0, reg_rdata} : {1'b1, ext_wr_sel, ext_wr_data};
                if (a !== e || (reg_rvalid && ext_wr_req)) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", t, a, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        ddr_hi = 8'hFF; ddr_lo = 8'hFF;
        #1;
        check("R1 upper reset", 16'(pad_out_hi), 16'h00);
        check("R1 lower reset", 16'(pad_out_lo), 16'h00);
        check("R1 rvalid reset", 16'(reg_rvalid), 16'h0);
        check("R1 ext_wr reset", 16'(ext_wr_req), 16'h0);

        // R2 / R3 single-chip writes and pads
        do_write(1'b0, 8'hA5, 1'b0, "R2 write upper");
        do_write(1'b1, 8'h3C, 1'b0, "R2 write lower");
        ddr_lo = 8'h0F; #1;
        check("R2 upper pads", 16'(pad_out_hi), 16'hA5);
        check("R3 upper oe", 16'(pad_oe_hi), 16'hFF);
        check("R3 lower pads", 16'(pad_out_lo), 16'h3C);
        check("R3 lower oe", 16'(pad_oe_lo), 16'h0F);

        // R4 mixed-direction local reads
        ddr_hi = 8'hF0; pad_in_hi = 8'h5A; pad_in_lo = 8'hC3;
        do_read(1'b0, 8'hAA, "R4 read upper mixed");
        do_read(1'b1, 8'hCC, "R4 read lower mixed");

        // R5 / R6 expanded mode
        mode = 2'b01; int_addr = 16'h1234; vis_data = 16'hABCD; vis_phase = 1'b0; #1;
        check("R5 addr upper", {pad_oe_hi, pad_out_hi}, 16'hFF12);
        check("R5 addr lower", {pad_oe_lo, pad_out_lo}, 16'hFF34);
        vis_phase = 1'b1; #1;
        check("R5 vis upper", 16'(pad_out_hi), 16'hAB);
        check("R5 vis lower", 16'(pad_out_lo), 16'hCD);
        uds_en = 1'b1; uds_val = 1'b0; #1;
        check("R6 strobe vis phase", 16'(pad_out_lo), 16'hCC);
        vis_phase = 1'b0; uds_val = 1'b1; #1;
        check("R6 strobe addr phase", 16'(pad_out_lo), 16'h35);
        check("R6 upper untouched", 16'(pad_out_hi), 16'h12);
        uds_en = 1'b0;
        mode = 2'b11; #1;
        check("R5 alt expanded oe", {pad_oe_hi, pad_oe_lo}, 16'hFFFF);
        mode = 2'b01;

        // R8 no external write outside emulation, R9 write while on bus
        do_write(1'b0, 8'h11, 1'b0, "R8 expanded write");
        do_read(1'b0, 8'h1A, "R4 expanded local read");

        // R7 / R8 emulation
        mode = 2'b10; ext_rd_data = 8'h77;
        do_read(1'b0, 8'h77, "R7 emulation read");
        do_write(1'b1, 8'h99, 1'b0, "R8 emulation write");
        mode = 2'b00; ddr_hi = 8'hFF; ddr_lo = 8'hFF; #1;
        check("R9 lower after bus use", 16'(pad_out_lo), 16'h99);
        check("R9 upper after bus use", 16'(pad_out_hi), 16'h11);

        // R10 simultaneous read and write
        do_write(1'b0, 8'h42, 1'b1, "R10 rd+wr");
        #1 check("R10 write taken", 16'(pad_out_hi), 16'h42);

        repeat (3) @(posedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R4/R7/R8 pending results: actual %0d expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule